// File: doc/BRIEF.md
# Flag-Delimited Ring Packet Receiver

This block sits behind a ring link. The link delivers one 16-bit symbol per clock, and a framing flag bit comes with each symbol. The receiver marks packet boundaries from the flag edges and decides whether each packet is an echo or an ordinary packet. It captures the destination node identifier carried in the first symbol and checks the CRC symbol that closes every packet. Downstream logic receives each packet as a symbol stream with start, end, echo, CRC-error and framing-error indications. The destination identifier is held for every beat of the packet.

The end of a packet is never signalled directly. A falling flag edge comes a fixed number of symbols before the last symbol, and that number depends on the packet kind. The kind is read from how long the flag stayed high. A high run of exactly one symbol marks an echo packet, which then ends one symbol after its first low-flag symbol. A longer run marks an ordinary packet, which ends four symbols after its first low-flag symbol. Both distances are parameters.

Top module: `ring_pkt_rx`

## Requirements
- R1: A symbol whose flag is 1 while the previous symbol's flag was 0 starts a packet. Its beat carries out_sop=1, and its value is shown on out_dest for every beat of that packet.
- R2: When the flag stays high for exactly one symbol, the packet is an echo. Its last symbol is the one after the first low-flag symbol. That beat carries out_eop=1 and out_echo=1. out_echo is 1 on every beat from the first low-flag symbol onward.
- R3: When the flag stays high for two or more symbols, the packet is ordinary. Its last symbol comes four symbols after the first low-flag symbol, and out_echo stays 0 throughout.
- R4: The last symbol of a packet is compared with a CRC-16 (polynomial 0x1021, initial value 0xFFFF, each symbol fed most significant bit first, no final inversion). The CRC covers every earlier symbol of the packet. A mismatch sets out_crc_err=1 on the end beat only.
- R5: A new packet may start on the symbol right after the last symbol of the previous one, with no idle symbol between them.
- R6: A rising flag while a packet is still open closes that packet. Its most recent beat carries out_eop=1 and out_frame_err=1 with out_crc_err=0, and the rising symbol starts a new packet normally.
- R7: A symbol that is neither inside a packet nor a packet start gives out_valid=0, and out_sop, out_eop, out_echo, out_crc_err and out_frame_err are all 0.
- R8: Each input symbol appears on out_data exactly two clock cycles after it is presented.
- R9: While rst_n is low all outputs are 0. Reception starts on the third rising clock edge after rst_n rises.
- R10: Every valid beat that is not a start beat directly follows a valid beat that was not an end beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 16 | Incoming link symbol |
| flag_i | input | 1 | Framing flag paired with sym_i |
| out_valid | output | 1 | Beat belongs to a packet |
| out_data | output | 16 | Symbol of the beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_echo | output | 1 | Packet classified as echo |
| out_crc_err | output | 1 | CRC mismatch on the end beat |
| out_frame_err | output | 1 | Packet closed early by a rising flag |
| out_dest | output | 16 | Destination identifier of the current packet |

## Verification
The bench sweeps ordinary flag runs of two to six symbols with good and corrupted CRC symbols, and echo packets with gaps of zero to two idle symbols. A receiver that counts the wrong distance after the falling edge puts out_eop on the wrong beat. One that classifies by the wrong run length swaps the echo indication and mistimes the end. Truncations are inserted at every offset after the fall. A design that ignores a rising flag inside an open packet merges two packets and drops the framing error. A CRC that does not restart at a start beat, or that takes in the CRC symbol itself, flags good packets as bad. A dest register that is not held leaves out_dest showing payload values.

// File: rtl/ring_pkt_rx_pkg.sv
package ring_pkt_rx_pkg;

  localparam int SYM_W = 16;

  typedef logic [SYM_W-1:0] sym_t;

  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
    logic echo;
    logic crc_err;
    logic frame_err;
    sym_t data;
    sym_t dest;
  } beat_t;

  // One full symbol through the CRC shift register, MSB first.
  function automatic sym_t crc_step(input sym_t crc, input sym_t sym, input sym_t poly);
    sym_t c;
    logic fb;
    c = crc;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      fb = c[SYM_W-1] ^ sym[i];
      c  = {c[SYM_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/ring_pkt_rx_framer.sv
module ring_pkt_rx_framer #(
  parameter int unsigned FALL_ECHO = 1,
  parameter int unsigned FALL_ORD  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic valid_o,
  output logic sop_o,
  output logic final_o,
  output logic echo_o,
  output logic abort_o
);

  localparam int unsigned FALL_MAX = (FALL_ECHO > FALL_ORD) ? FALL_ECHO : FALL_ORD;
  localparam int CNT_W = $clog2(FALL_MAX + 1);

  logic             flag_q,   flag_n;
  logic             open_q,   open_n;
  logic             fallen_q, fallen_n;
  logic             first_q,  first_n;
  logic             echo_q,   echo_n;
  logic [CNT_W-1:0] cnt_q,    cnt_n;
  logic             rise;

  assign rise = flag_i & ~flag_q;

  always_comb begin
    flag_n   = flag_i;
    open_n   = open_q;
    fallen_n = fallen_q;
    first_n  = first_q;
    echo_n   = echo_q;
    cnt_n    = cnt_q;
    valid_o  = 1'b0;
    sop_o    = 1'b0;
    final_o  = 1'b0;
    echo_o   = 1'b0;
    abort_o  = 1'b0;
    if (rise) begin
      abort_o  = open_q;
      valid_o  = 1'b1;
      sop_o    = 1'b1;
      open_n   = 1'b1;
      fallen_n = 1'b0;
      first_n  = 1'b1;
      echo_n   = 1'b0;
      cnt_n    = '0;
    end else if (open_q) begin
      valid_o = 1'b1;
      first_n = 1'b0;
      if (!fallen_q) begin
        if (!flag_i) begin
          fallen_n = 1'b1;
          echo_n   = first_q;
          echo_o   = first_q;
          cnt_n    = first_q ? CNT_W'(FALL_ECHO) : CNT_W'(FALL_ORD);
        end
      end else begin
        echo_o  = echo_q;
        final_o = (cnt_q == CNT_W'(1));
        cnt_n   = cnt_q - CNT_W'(1);
        if (final_o) open_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      open_q   <= 1'b0;
      fallen_q <= 1'b0;
      first_q  <= 1'b0;
      echo_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      flag_q   <= flag_n;
      open_q   <= open_n;
      fallen_q <= fallen_n;
      first_q  <= first_n;
      echo_q   <= echo_n;
      cnt_q    <= cnt_n;
    end
  end

  p_end_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    final_o |-> (fallen_q && open_q));

  p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && fallen_q) |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(FALL_MAX)));

endmodule

// File: rtl/ring_pkt_rx_crc.sv
module ring_pkt_rx_crc
  import ring_pkt_rx_pkg::*;
#(
  parameter sym_t CRC_POLY = 16'h1021,
  parameter sym_t CRC_INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic sop_i,
  input  logic final_i,
  input  sym_t sym_i,
  output logic err_o
);

  sym_t crc_q, crc_n;
  logic crc_en;

  assign crc_en = sop_i | (valid_i & ~final_i);

  always_comb begin
    crc_n = crc_q;
    if (sop_i)       crc_n = crc_step(CRC_INIT, sym_i, CRC_POLY);
    else if (crc_en) crc_n = crc_step(crc_q, sym_i, CRC_POLY);
  end

  assign err_o = final_i & (sym_i != crc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_INIT;
    else if (crc_en) crc_q <= crc_n;
  end

  p_crc_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(crc_q));

endmodule

// File: rtl/ring_pkt_rx_outstage.sv
module ring_pkt_rx_outstage
  import ring_pkt_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  sym_t  sym_i,
  input  logic  valid_i,
  input  logic  sop_i,
  input  logic  final_i,
  input  logic  echo_i,
  input  logic  crc_err_i,
  input  logic  abort_i,
  output beat_t beat_o
);

  beat_t a_q, a_n;
  beat_t b_q, b_n;

  always_comb begin
    a_n.valid     = valid_i;
    a_n.sop       = sop_i;
    a_n.eop       = final_i;
    a_n.echo      = echo_i;
    a_n.crc_err   = crc_err_i;
    a_n.frame_err = 1'b0;
    a_n.data      = sym_i;
    a_n.dest      = sop_i ? sym_i : a_q.dest;
  end

  // A rising flag seen now closes the beat held in the first stage.
  always_comb begin
    b_n = a_q;
    if (abort_i && a_q.valid) begin
      b_n.eop       = 1'b1;
      b_n.frame_err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_n;
      b_q <= b_n;
    end
  end

  assign beat_o = b_q;

  p_cont_follows_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q.valid && !b_q.sop) |-> ($past(b_q.valid) && !$past(b_q.eop)));

  p_frame_err_is_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_q.frame_err |-> (b_q.eop && !b_q.crc_err));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !b_q.valid |-> !(b_q.sop || b_q.eop || b_q.echo || b_q.crc_err || b_q.frame_err));

  p_dest_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q.valid && !b_q.sop) |-> $stable(b_q.dest));

endmodule

// File: rtl/ring_pkt_rx.sv
module ring_pkt_rx
  import ring_pkt_rx_pkg::*;
#(
  parameter int unsigned FALL_ECHO = 1,
  parameter int unsigned FALL_ORD  = 4,
  parameter sym_t        CRC_POLY  = 16'h1021,
  parameter sym_t        CRC_INIT  = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] sym_i,
  input  logic        flag_i,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        out_echo,
  output logic        out_crc_err,
  output logic        out_frame_err,
  output logic [15:0] out_dest
);

  logic  rst_s1_q, rst_s2_q;
  logic  core_rst_n;
  logic  f_valid, f_sop, f_final, f_echo, f_abort;
  logic  c_err;
  beat_t beat;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign core_rst_n = rst_s2_q;

  ring_pkt_rx_framer #(
    .FALL_ECHO (FALL_ECHO),
    .FALL_ORD  (FALL_ORD)
  ) u_framer (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .flag_i  (flag_i),
    .valid_o (f_valid),
    .sop_o   (f_sop),
    .final_o (f_final),
    .echo_o  (f_echo),
    .abort_o (f_abort)
  );

  ring_pkt_rx_crc #(
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT)
  ) u_crc (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .valid_i (f_valid),
    .sop_i   (f_sop),
    .final_i (f_final),
    .sym_i   (sym_i),
    .err_o   (c_err)
  );

  ring_pkt_rx_outstage u_out (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .sym_i     (sym_i),
    .valid_i   (f_valid),
    .sop_i     (f_sop),
    .final_i   (f_final),
    .echo_i    (f_echo),
    .crc_err_i (c_err),
    .abort_i   (f_abort),
    .beat_o    (beat)
  );

  assign out_valid     = beat.valid;
  assign out_data      = beat.data;
  assign out_sop       = beat.sop;
  assign out_eop       = beat.eop;
  assign out_echo      = beat.echo;
  assign out_crc_err   = beat.crc_err;
  assign out_frame_err = beat.frame_err;
  assign out_dest      = beat.dest;

endmodule

// File: tb/ring_pkt_rx_test.sv
module ring_pkt_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXN       = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sym_i = '0;
  logic        flag_i = 1'b0;
  logic        out_valid, out_sop, out_eop, out_echo, out_crc_err, out_frame_err;
  logic [15:0] out_data, out_dest;

  ring_pkt_rx uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sym_i         (sym_i),
    .flag_i        (flag_i),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_sop       (out_sop),
    .out_eop       (out_eop),
    .out_echo      (out_echo),
    .out_crc_err   (out_crc_err),
    .out_frame_err (out_frame_err),
    .out_dest      (out_dest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] q_sym  [MAXN];
  logic        q_flag [MAXN];
  logic [5:0]  q_exp  [MAXN];   // {valid, sop, eop, echo, crc_err, frame_err}
  logic [15:0] q_dest [MAXN];
  string       q_tag  [MAXN];
  int n = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [15:0] ref_crc(input logic [15:0] seed, input logic [15:0] s);
    logic [15:0] c;
    c = seed;
    for (int b = 15; b >= 0; b--) begin
      if (c[15] ^ s[b]) c = (c << 1) ^ 16'h1021;
      else              c = c << 1;
    end
    return c;
  endfunction

  function void push(input logic [15:0] s, input logic f, input logic [5:0] e,
                     input logic [15:0] d, input string t);
    q_sym[n] = s; q_flag[n] = f; q_exp[n] = e; q_dest[n] = d; q_tag[n] = t;
    n++;
  endfunction

  function void add_idle(input int k);
    for (int i = 0; i < k; i++) push(16'hC3C3 ^ 16'(i), 1'b0, 6'b0, 16'h0, "R7");
  endfunction

  // run==1 builds an echo packet; trunc>0 stops trunc symbols after the fall.
  function void add_pkt(input logic [15:0] dest, input int run, input int trunc,
                        input bit bad, input string sop_tag);
    int d, len, emit;
    logic [15:0] crc, s;
    logic eop, fe, ce, ec;
    string t;
    d    = (run == 1) ? 1 : 4;
    len  = run + d + 1;
    emit = (trunc > 0) ? run + trunc : len;
    crc  = 16'hFFFF;
    for (int i = 0; i < emit; i++) begin
      if (i == 0)            s = dest;
      else if (i == len - 1) s = crc ^ (bad ? 16'h0100 : 16'h0000);
      else                   s = 16'(dest ^ 16'(i * 16'h2D31) ^ 16'h5A00);
      if (i < len - 1) crc = ref_crc(crc, s);
      eop = (i == emit - 1);
      fe  = eop && (trunc > 0);
      ce  = eop && bad && (trunc == 0);
      ec  = (run == 1) && (i >= run);
      if (i == 0)   t = sop_tag;
      else if (fe)  t = "R6";
      else if (eop) t = bad ? "R4" : ((run == 1) ? "R2" : "R3");
      else          t = "R8";
      push(s, (i < run), {1'b1, (i == 0), eop, ec, ce, fe}, dest, t);
    end
  endfunction

  task automatic check_beat(input int i);
    logic [5:0] got;
    got = {out_valid, out_sop, out_eop, out_echo, out_crc_err, out_frame_err};
    checks++;
    if (got !== q_exp[i]) begin
      fails++;
      $display("FAIL %s beat %0d flags got %b exp %b", q_tag[i], i, got, q_exp[i]);
    end else if (q_exp[i][5] && (out_data !== q_sym[i] || out_dest !== q_dest[i])) begin
      fails++;
      $display("FAIL %s beat %0d data/dest got %h/%h exp %h/%h", q_tag[i], i,
               out_data, out_dest, q_sym[i], q_dest[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    add_idle(4);
    // R3 and R4: ordinary runs 2..6, good and bad CRC, gaps of 0..2 (R5 when 0)
    for (int run = 2; run <= 6; run++) begin
      for (int bad = 0; bad < 2; bad++) begin
        add_pkt(16'hA000 + 16'(run * 16 + bad), run, 0, bad[0], "R1");
        add_idle((run + bad) % 3);
      end
    end
    // R2: echo packets, good and bad CRC, gaps 0..2
    for (int bad = 0; bad < 2; bad++) begin
      for (int gap = 0; gap < 3; gap++) begin
        add_pkt(16'h0E00 + 16'(gap), 1, 0, bad[0], "R1");
        add_idle(gap);
      end
    end
    // R5: back-to-back packets, extreme destinations
    add_pkt(16'h0000, 3, 0, 1'b0, "R1");
    add_pkt(16'hFFFF, 2, 0, 1'b0, "R5");
    add_pkt(16'h8001, 1, 0, 1'b0, "R5");
    add_idle(2);
    // R6: truncation at every offset after the fall, then a normal packet
    for (int k = 1; k <= 4; k++) begin
      add_pkt(16'h7700 + 16'(k), 3, k, 1'b0, "R1");
      add_pkt(16'h7780 + 16'(k), 2, 0, k[0], "R6");
      add_idle(1);
    end
    add_pkt(16'h5E00, 1, 1, 1'b0, "R1");
    add_pkt(16'h5E01, 1, 0, 1'b0, "R6");
    add_idle(4);

    // R9: outputs quiet during reset
    repeat (3) begin
      @(negedge clk);
      checks++;
      if ({out_valid, out_sop, out_eop, out_echo, out_crc_err, out_frame_err,
           out_data, out_dest} !== '0) begin
        fails++;
        $display("FAIL R9 reset outputs got %b/%h/%h exp 0",
                 {out_valid, out_sop, out_eop, out_echo, out_crc_err, out_frame_err},
                 out_data, out_dest);
      end
    end

    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i == 0) rst_n = 1'b1;
      if (i >= 2) check_beat(i - 2);
      if (i < n) begin
        sym_i  = q_sym[i];
        flag_i = q_flag[i];
      end else begin
        sym_i  = 16'h0;
        flag_i = 1'b0;
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule